// File: doc/BRIEF.md
# Floating-point load unit

This unit carries out a floating-point load once the instruction word has been fetched. It takes the 32-bit instruction, the value of the integer base register and two configuration levels. The first level says whether double precision is present. The second says whether the floating-point state is enabled. The unit decodes the access width, forms the effective address and checks legality and alignment. It then issues one read over a valid/ready memory request channel and waits for the matching response. Finally it writes the formatted value to the floating-point register file port or reports an exception cause.

Values narrower than the register are NaN-boxed, which means their upper bits are filled with ones. The loaded bits themselves pass through unchanged, so NaN payloads are never canonicalised. A successful load also pulses a dirty flag for the floating-point state. Address translation happens outside this unit. Its failure arrives as a fault flag and cause on the memory response.

The instruction channel and the memory request channel are valid/ready. An instruction is taken when `issue_valid` and `issue_ready` are both high at a clock edge. `issue_ready` stays low from acceptance until the cycle in which the result is shown. A memory request, once raised, holds its address and size until `mem_req_ready` is seen, and only one request is ever outstanding. The response channel is accepted only while `mem_rsp_ready` is high. The register write and completion outputs are single-cycle pulses with no back-pressure, so the consumer must take them in the cycle they appear.

Top module: `fp_load_unit`

## Requirements
- R1: The effective address is `issue_base` plus the sign-extended 12-bit immediate taken from instruction bits [31:20]. The destination register index on `fp_wr_idx` is instruction bits [11:7].
- R2: Instruction bits [14:12] select the width: 001 is half (`mem_req_size`=1, 2 bytes), 010 is word (size 2, 4 bytes) and 011 is double (size 3, 8 bytes). 000 (byte) and every other value complete with `done_exc`=1, `done_cause`=2 (illegal instruction), no memory request and no register write.
- R3: With `cfg_dbl_present`=0 the double width is illegal: cause 2, no request, no write.
- R4: With `cfg_fs_on`=0 every instruction completes with cause 2, no request and no write. This check takes priority over the width and alignment checks.
- R5: An effective address whose low bits are not zero for the selected width completes with cause 4 (load address misaligned), no request and no write. Every request that is issued is aligned to its size.
- R6: A response with `mem_rsp_fault`=1 completes with `done_exc`=1 and `done_cause` equal to `mem_rsp_cause`. No register is written and no dirty pulse is given.
- R7: Boxing of the response data uses only its low bytes. With double precision present, a half value gets bits [63:16] set to ones and a word value gets bits [63:32] set to ones. With double precision absent, a half value gets bits [31:16] set to ones and bits [63:32] set to zero, and a word value gets bits [63:32] set to zero. A double value is written as received.
- R8: The loaded bits reach `fp_wr_data` bit-exact, including the payloads of non-canonical NaNs.
- R9: A successful load raises `fp_wr_valid`, `done_valid` and `fs_dirty` together for one cycle. This happens in the cycle after the response is accepted, whatever the data value.
- R10: While `mem_req_ready` is low, `mem_req_valid`, `mem_req_addr` and `mem_req_size` hold. `issue_ready` is low while a request or response is pending.
- R11: After reset, `issue_ready` is high and `mem_req_valid`, `done_valid`, `fp_wr_valid` and `fs_dirty` are low.
- R12: A rejected instruction (R2 to R5) completes in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle, instruction can be taken |
| issue_insn | input | 32 | Load instruction word |
| issue_base | input | XLEN | Base register value |
| cfg_dbl_present | input | 1 | Double precision implemented |
| cfg_fs_on | input | 1 | Floating-point state enabled |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | XLEN | Read byte address |
| mem_req_size | output | 2 | log2 of the byte count |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_ready | output | 1 | Unit waits for a response |
| mem_rsp_data | input | FLEN | Read data, right-aligned |
| mem_rsp_fault | input | 1 | Translation or access fault |
| mem_rsp_cause | input | 5 | Exception cause of the fault |
| fp_wr_valid | output | 1 | Register write pulse |
| fp_wr_idx | output | 5 | Destination register index |
| fp_wr_data | output | FLEN | Formatted register value |
| done_valid | output | 1 | Instruction finished |
| done_exc | output | 1 | Finished with an exception |
| done_cause | output | 5 | Exception cause |
| fs_dirty | output | 1 | Floating-point state dirty pulse |

## Verification
A stuck or wrong control state shows up as a missing or early completion pulse. It also shows up as a request that drops or changes while stalled, or as `issue_ready` rising while a request is pending. All of these are visible within one cycle of the stall or response. A wrong latched size, base or precision flag appears in the response's single completion cycle as a bad address, a bad request size, or wrong upper bits in `fp_wr_data`. A decode fault appears as an exception or request that should not exist, one cycle after acceptance.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
  localparam int CAUSE_W = 5;
  localparam int IDX_W   = 5;
  localparam int SIZE_W  = 2;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL     = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_LD_MISALIGN = 5'd4;

  localparam logic [2:0] F3_HALF   = 3'b001;
  localparam logic [2:0] F3_WORD   = 3'b010;
  localparam logic [2:0] F3_DOUBLE = 3'b011;

  // log2 of the access size in bytes
  localparam logic [SIZE_W-1:0] SZ_NONE = 2'd0;
  localparam logic [SIZE_W-1:0] SZ_HALF = 2'd1;
  localparam logic [SIZE_W-1:0] SZ_WORD = 2'd2;
  localparam logic [SIZE_W-1:0] SZ_DBL  = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RESP = 2'd2
  } fpl_state_e;
endpackage

// File: rtl/fpl_decode.sv
module fpl_decode
  import fpl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]         insn,
  input  logic [XLEN-1:0]     base,
  input  logic                dbl_present,
  input  logic                fs_on,
  output logic [XLEN-1:0]     addr,
  output logic [SIZE_W-1:0]   size,
  output logic [IDX_W-1:0]    rd,
  output logic                exc,
  output logic [CAUSE_W-1:0]  cause
);
  localparam int IMM_W   = 12;
  localparam int ALIGN_W = 3;

  logic [IMM_W-1:0]   imm;
  logic [2:0]         width_sel;
  logic               width_ok;
  logic [ALIGN_W-1:0] low_mask;
  logic               misaligned;
  logic               unused_fields;

  assign imm       = insn[31:20];
  assign width_sel = insn[14:12];
  assign rd        = insn[11:7];
  // base index and opcode are resolved before this unit
  assign unused_fields = ^{insn[19:15], insn[6:0]};

  assign addr = base + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    size     = SZ_NONE;
    width_ok = 1'b0;
    case (width_sel)
      F3_HALF:   begin size = SZ_HALF; width_ok = 1'b1;        end
      F3_WORD:   begin size = SZ_WORD; width_ok = 1'b1;        end
      F3_DOUBLE: begin size = SZ_DBL;  width_ok = dbl_present; end
      default:   begin size = SZ_NONE; width_ok = 1'b0;        end
    endcase
  end

  for (genvar b = 0; b < ALIGN_W; b++) begin : g_mask
    assign low_mask[b] = (size > SIZE_W'(b));
  end
  assign misaligned = |(addr[ALIGN_W-1:0] & low_mask);

  always_comb begin
    exc   = 1'b0;
    cause = '0;
    if (!fs_on) begin
      exc   = 1'b1;
      cause = CAUSE_ILLEGAL;
    end else if (!width_ok) begin
      exc   = 1'b1;
      cause = CAUSE_ILLEGAL;
    end else if (misaligned) begin
      exc   = 1'b1;
      cause = CAUSE_LD_MISALIGN;
    end
  end
endmodule

// File: rtl/fpl_format.sv
module fpl_format
  import fpl_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [FLEN-1:0]   raw,
  input  logic [SIZE_W-1:0] size,
  input  logic              dbl_present,
  output logic [FLEN-1:0]   value
);
  localparam int HALF_W = 16;
  localparam int SGL_W  = 32;

  logic [HALF_W-1:0] half_bits;
  logic [SGL_W-1:0]  sgl_bits;
  logic [FLEN-1:0]   half_wide;
  logic [FLEN-1:0]   half_narrow;
  logic [FLEN-1:0]   sgl_wide;
  logic [FLEN-1:0]   sgl_narrow;

  assign half_bits = raw[HALF_W-1:0];
  assign sgl_bits  = raw[SGL_W-1:0];

  assign half_wide   = {{(FLEN-HALF_W){1'b1}}, half_bits};
  assign half_narrow = {{(FLEN-SGL_W){1'b0}}, {(SGL_W-HALF_W){1'b1}}, half_bits};
  assign sgl_wide    = {{(FLEN-SGL_W){1'b1}}, sgl_bits};
  assign sgl_narrow  = {{(FLEN-SGL_W){1'b0}}, sgl_bits};

  always_comb begin
    case (size)
      SZ_HALF: value = dbl_present ? half_wide : half_narrow;
      SZ_WORD: value = dbl_present ? sgl_wide  : sgl_narrow;
      default: value = raw;
    endcase
  end
endmodule

// File: rtl/fp_load_unit.sv
module fp_load_unit
  import fpl_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int FLEN = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_valid,
  output logic                issue_ready,
  input  logic [31:0]         issue_insn,
  input  logic [XLEN-1:0]     issue_base,
  input  logic                cfg_dbl_present,
  input  logic                cfg_fs_on,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [XLEN-1:0]     mem_req_addr,
  output logic [SIZE_W-1:0]   mem_req_size,
  input  logic                mem_rsp_valid,
  output logic                mem_rsp_ready,
  input  logic [FLEN-1:0]     mem_rsp_data,
  input  logic                mem_rsp_fault,
  input  logic [CAUSE_W-1:0]  mem_rsp_cause,
  output logic                fp_wr_valid,
  output logic [IDX_W-1:0]    fp_wr_idx,
  output logic [FLEN-1:0]     fp_wr_data,
  output logic                done_valid,
  output logic                done_exc,
  output logic [CAUSE_W-1:0]  done_cause,
  output logic                fs_dirty
);
  fpl_state_e          st;
  logic                issue_fire;
  logic [XLEN-1:0]     dec_addr;
  logic [SIZE_W-1:0]   dec_size;
  logic [IDX_W-1:0]    dec_rd;
  logic                dec_exc;
  logic [CAUSE_W-1:0]  dec_cause;
  logic [XLEN-1:0]     lat_addr;
  logic [SIZE_W-1:0]   lat_size;
  logic [IDX_W-1:0]    lat_rd;
  logic                lat_dbl;
  logic [FLEN-1:0]     fmt_value;

  fpl_decode #(.XLEN(XLEN)) u_decode (
    .insn        (issue_insn),
    .base        (issue_base),
    .dbl_present (cfg_dbl_present),
    .fs_on       (cfg_fs_on),
    .addr        (dec_addr),
    .size        (dec_size),
    .rd          (dec_rd),
    .exc         (dec_exc),
    .cause       (dec_cause)
  );

  fpl_format #(.FLEN(FLEN)) u_format (
    .raw         (mem_rsp_data),
    .size        (lat_size),
    .dbl_present (lat_dbl),
    .value       (fmt_value)
  );

  assign issue_ready   = (st == ST_IDLE);
  assign issue_fire    = issue_valid && issue_ready;
  assign mem_req_valid = (st == ST_REQ);
  assign mem_rsp_ready = (st == ST_RESP);
  assign mem_req_addr  = lat_addr;
  assign mem_req_size  = lat_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      lat_addr    <= '0;
      lat_size    <= SZ_NONE;
      lat_rd      <= '0;
      lat_dbl     <= 1'b0;
      fp_wr_valid <= 1'b0;
      fp_wr_idx   <= '0;
      fp_wr_data  <= '0;
      done_valid  <= 1'b0;
      done_exc    <= 1'b0;
      done_cause  <= '0;
      fs_dirty    <= 1'b0;
    end else begin
      fp_wr_valid <= 1'b0;
      done_valid  <= 1'b0;
      done_exc    <= 1'b0;
      fs_dirty    <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (issue_fire) begin
            lat_addr <= dec_addr;
            lat_size <= dec_size;
            lat_rd   <= dec_rd;
            lat_dbl  <= cfg_dbl_present;
            if (dec_exc) begin
              done_valid <= 1'b1;
              done_exc   <= 1'b1;
              done_cause <= dec_cause;
            end else begin
              st <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) st <= ST_RESP;
        end
        ST_RESP: begin
          if (mem_rsp_valid) begin
            st         <= ST_IDLE;
            done_valid <= 1'b1;
            if (mem_rsp_fault) begin
              done_exc   <= 1'b1;
              done_cause <= mem_rsp_cause;
            end else begin
              fp_wr_valid <= 1'b1;
              fp_wr_idx   <= lat_rd;
              fp_wr_data  <= fmt_value;
              fs_dirty    <= 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ((mem_req_size == SZ_HALF && !mem_req_addr[0]) ||
                       (mem_req_size == SZ_WORD && mem_req_addr[1:0] == 2'b00) ||
                       (mem_req_size == SZ_DBL  && mem_req_addr[2:0] == 3'b000))); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size)); // R10

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || mem_rsp_ready) |-> !issue_ready); // R10

  AST_WRITE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    fp_wr_valid |-> done_valid && !done_exc && fs_dirty); // R9

  AST_BYTE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && issue_valid && issue_ready && issue_insn[14:12] == 3'b000)
      |-> done_valid && done_exc && done_cause == CAUSE_ILLEGAL && !mem_req_valid); // R2

  AST_FS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && issue_valid && issue_ready && !cfg_fs_on)
      |-> done_valid && done_exc && done_cause == CAUSE_ILLEGAL && !fp_wr_valid); // R4

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && mem_rsp_valid && mem_rsp_ready && mem_rsp_fault)
      |-> done_exc && !fp_wr_valid && !fs_dirty); // R6
endmodule

// File: tb/fp_load_unit_bench.sv
module fp_load_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [31:0] issue_insn = '0;
  logic [31:0] issue_base = '0;
  logic        cfg_dbl_present = 1'b1;
  logic        cfg_fs_on = 1'b1;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_fault = 1'b0;
  logic [4:0]  mem_rsp_cause = '0;
  logic        fp_wr_valid;
  logic [4:0]  fp_wr_idx;
  logic [63:0] fp_wr_data;
  logic        done_valid;
  logic        done_exc;
  logic [4:0]  done_cause;
  logic        fs_dirty;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_load_unit u_fp_load_unit (
    .clk, .rst_n, .issue_valid, .issue_ready, .issue_insn, .issue_base,
    .cfg_dbl_present, .cfg_fs_on, .mem_req_valid, .mem_req_ready,
    .mem_req_addr, .mem_req_size, .mem_rsp_valid, .mem_rsp_ready,
    .mem_rsp_data, .mem_rsp_fault, .mem_rsp_cause, .fp_wr_valid,
    .fp_wr_idx, .fp_wr_data, .done_valid, .done_exc, .done_cause, .fs_dirty
  );

  typedef struct packed {
    logic [2:0]  f3;
    logic [11:0] imm;
    logic [31:0] base;
    logic [4:0]  rd;
    logic        dbl;
    logic        fs;
    logic [63:0] rdata;
    logic        exc;
    logic [4:0]  cause;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  // R7 R8 boxing and payloads; R2 R3 R4 R5 rejection paths
  localparam vec_t VECS [14] = '{
    '{3'b010, 12'h008, 32'h1000, 5'd5,  1'b1, 1'b1, 64'hDEADBEEF_3F800000, 1'b0, 5'd0, 64'hFFFFFFFF_3F800000, 4'd7},
    '{3'b010, 12'hFFC, 32'h2000, 5'd6,  1'b0, 1'b1, 64'h12345678_7FA00001, 1'b0, 5'd0, 64'h00000000_7FA00001, 4'd8},
    '{3'b001, 12'h002, 32'h0100, 5'd7,  1'b1, 1'b1, 64'hDEADBEEF_12347E01, 1'b0, 5'd0, 64'hFFFFFFFF_FFFF7E01, 4'd7},
    '{3'b001, 12'h000, 32'h0200, 5'd8,  1'b0, 1'b1, 64'hAAAAAAAA_55557C01, 1'b0, 5'd0, 64'h00000000_FFFF7C01, 4'd7},
    '{3'b011, 12'h010, 32'h3000, 5'd9,  1'b1, 1'b1, 64'h7FF00000_00000ABC, 1'b0, 5'd0, 64'h7FF00000_00000ABC, 4'd8},
    '{3'b011, 12'h000, 32'h3000, 5'd10, 1'b0, 1'b1, 64'h0, 1'b1, 5'd2, 64'h0, 4'd3},
    '{3'b000, 12'h000, 32'h1000, 5'd11, 1'b1, 1'b1, 64'h0, 1'b1, 5'd2, 64'h0, 4'd2},
    '{3'b100, 12'h000, 32'h1000, 5'd12, 1'b1, 1'b1, 64'h0, 1'b1, 5'd2, 64'h0, 4'd2},
    '{3'b010, 12'h000, 32'h1002, 5'd13, 1'b1, 1'b1, 64'h0, 1'b1, 5'd4, 64'h0, 4'd5},
    '{3'b001, 12'h000, 32'h0101, 5'd14, 1'b1, 1'b1, 64'h0, 1'b1, 5'd4, 64'h0, 4'd5},
    '{3'b011, 12'h004, 32'h1000, 5'd15, 1'b1, 1'b1, 64'h0, 1'b1, 5'd4, 64'h0, 4'd5},
    '{3'b010, 12'h000, 32'h1000, 5'd16, 1'b1, 1'b0, 64'h0, 1'b1, 5'd2, 64'h0, 4'd4},
    '{3'b011, 12'h001, 32'h1000, 5'd17, 1'b0, 1'b0, 64'h0, 1'b1, 5'd2, 64'h0, 4'd4},
    '{3'b111, 12'h000, 32'h1000, 5'd18, 1'b1, 1'b1, 64'h0, 1'b1, 5'd2, 64'h0, 4'd2}
  };

  int n_run = 0;
  int n_fail = 0;

  bit          saw_req, saw_done, stall_ok, busy_ok, pulse_ok, rsp_rdy_ok;
  logic [31:0] cap_addr;
  logic [1:0]  cap_size;
  logic        cap_exc, cap_wr, cap_dirty;
  logic [4:0]  cap_cause, cap_idx;
  logic [63:0] cap_data;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] f3, input logic [11:0] imm, input logic [4:0] rd);
    return {imm, 5'd1, f3, rd, 7'b0000111};
  endfunction

  task automatic capture();
    saw_done  = done_valid;
    cap_exc   = done_exc;
    cap_cause = done_cause;
    cap_wr    = fp_wr_valid;
    cap_idx   = fp_wr_idx;
    cap_data  = fp_wr_data;
    cap_dirty = fs_dirty;
  endtask

  task automatic do_op(input logic [31:0] insn, input logic [31:0] base, input logic dbl,
                       input logic fs, input logic [63:0] rdata, input logic fault,
                       input logic [4:0] fcause, input int req_dly, input int rsp_dly);
    saw_req = 0; saw_done = 0; stall_ok = 1; busy_ok = 1; rsp_rdy_ok = 1;
    cap_exc = 0; cap_wr = 0; cap_dirty = 0;
    @(negedge clk);
    issue_valid = 1'b1; issue_insn = insn; issue_base = base;
    cfg_dbl_present = dbl; cfg_fs_on = fs;
    @(negedge clk);
    issue_valid = 1'b0;
    if (done_valid) begin
      capture();
    end else if (mem_req_valid) begin
      saw_req = 1; cap_addr = mem_req_addr; cap_size = mem_req_size;
      for (int i = 0; i < req_dly; i++) begin
        if (issue_ready) busy_ok = 0;
        @(negedge clk);
        if (!mem_req_valid || mem_req_addr != cap_addr || mem_req_size != cap_size) stall_ok = 0;
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      for (int i = 0; i < rsp_dly; i++) begin
        if (issue_ready || done_valid || !mem_rsp_ready) busy_ok = 0;
        @(negedge clk);
      end
      if (!mem_rsp_ready) rsp_rdy_ok = 0;
      mem_rsp_valid = 1'b1; mem_rsp_data = rdata; mem_rsp_fault = fault; mem_rsp_cause = fcause;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_fault = 1'b0;
      if (done_valid) capture();
    end
    @(negedge clk);
    pulse_ok = !done_valid && !fp_wr_valid && !fs_dirty && issue_ready;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    chk(issue_ready === 1'b1, "R11 issue_ready in reset", issue_ready, 1);
    chk({mem_req_valid, done_valid, fp_wr_valid, fs_dirty} === 4'b0, "R11 outputs in reset",
        {mem_req_valid, done_valid, fp_wr_valid, fs_dirty}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(issue_ready === 1'b1 && mem_req_valid === 1'b0, "R11 after release",
        {issue_ready, mem_req_valid}, 2'b10);

    for (int i = 0; i < 14; i++) begin
      automatic vec_t v = VECS[i];
      automatic logic [31:0] ea = v.base + {{20{v.imm[11]}}, v.imm};
      automatic string tag = $sformatf("R%0d vec %0d", v.req, i);
      do_op(mk(v.f3, v.imm, v.rd), v.base, v.dbl, v.fs, v.rdata, 1'b0, 5'd0, 0, 0);
      if (!v.exc) begin
        chk(saw_req, {tag, " R1 request"}, saw_req, 1);
        chk(cap_addr == ea, {tag, " R1 address"}, cap_addr, ea);
        chk(cap_size == v.f3[1:0], {tag, " R2 size"}, cap_size, v.f3[1:0]);
        chk(saw_done && !cap_exc && cap_wr && cap_dirty, {tag, " R9 completion"},
            {saw_done, cap_exc, cap_wr, cap_dirty}, 4'b1011);
        chk(cap_idx == v.rd, {tag, " R1 index"}, cap_idx, v.rd);
        chk(cap_data == v.exp, {tag, " data"}, cap_data, v.exp);
        chk(pulse_ok, {tag, " R9 pulse"}, pulse_ok, 1);
      end else begin
        chk(!saw_req, {tag, " no request"}, saw_req, 0);
        chk(saw_done && cap_exc, {tag, " R12 exception next cycle"}, {saw_done, cap_exc}, 2'b11);
        chk(cap_cause == v.cause, {tag, " cause"}, cap_cause, v.cause);
        chk(!cap_wr && !cap_dirty, {tag, " no write"}, {cap_wr, cap_dirty}, 0);
      end
    end

    // R1: most negative immediate and top register index
    do_op(mk(3'b010, 12'h800, 5'd31), 32'h0000_1000, 1'b1, 1'b1, 64'h0000_0000_4049_0FDB, 1'b0, 5'd0, 0, 0);
    chk(cap_addr == 32'h0000_0800, "R1 negative offset", cap_addr, 32'h800);
    chk(cap_idx == 5'd31, "R1 index 31", cap_idx, 31);

    // R10: stalled request and slow response
    do_op(mk(3'b011, 12'h008, 5'd3), 32'h0000_4000, 1'b1, 1'b1, 64'hFFF8_0000_0000_0001, 1'b0, 5'd0, 3, 2);
    chk(stall_ok, "R10 request held", stall_ok, 1);
    chk(busy_ok && rsp_rdy_ok, "R10 busy while pending", {busy_ok, rsp_rdy_ok}, 2'b11);
    chk(saw_done && cap_data == 64'hFFF8_0000_0000_0001, "R8 double after stalls", cap_data, 64'hFFF8_0000_0000_0001);

    // R9: same latency for different data values
    do_op(mk(3'b010, 12'h000, 5'd4), 32'h0000_5000, 1'b1, 1'b1, 64'h0, 1'b0, 5'd0, 1, 1);
    chk(saw_done && cap_wr, "R9 latency data zero", saw_done, 1);
    do_op(mk(3'b010, 12'h000, 5'd4), 32'h0000_5000, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'd0, 1, 1);
    chk(saw_done && cap_wr && cap_data == 64'hFFFF_FFFF_FFFF_FFFF, "R9 latency data ones", cap_data, 64'hFFFF_FFFF_FFFF_FFFF);

    // R6: fault reported with the response
    do_op(mk(3'b010, 12'h004, 5'd9), 32'h0000_6000, 1'b1, 1'b1, 64'h1234, 1'b1, 5'd13, 1, 2);
    chk(saw_done && cap_exc, "R6 fault completes", {saw_done, cap_exc}, 2'b11);
    chk(cap_cause == 5'd13, "R6 fault cause", cap_cause, 13);
    chk(!cap_wr && !cap_dirty, "R6 no write", {cap_wr, cap_dirty}, 0);
    chk(pulse_ok, "R6 idle afterwards", pulse_ok, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule